// File: doc/BRIEF.md
# GPIB Parallel Poll Responder

This block produces an instrument's answer to a parallel poll on an IEEE 488 bus. The host sets it up by writing a configuration byte into the auxiliary mode port. That byte carries an enable/disable choice, a sense bit and the number of the data line to answer on. The host keeps a single-bit local service flag up to date through a separate write port.

While the block is enabled and the bus shows the identify condition (ATN and EOI both asserted), it compares the sense bit with the service flag. When they are equal, it raises the chosen bit of an 8-bit active-high response vector. This happens on every poll, and the host takes no part in the poll itself.

Configuration and flag writes take effect at the next rising clock edge. The response is combinational from the stored state and the ATN and EOI lines. The block can be cleared in two ways: by its synchronous reset input, or by writing the local reset command byte to the auxiliary port. Either clears the flag and the whole configuration. The open-collector drivers and remote configuration by bus commands are handled elsewhere.

Top module: `pp_responder`

## Requirements
- R1: An auxiliary write whose bits [7:5] are 3'b011 is a poll configuration byte. Bit 4 is the disable bit U, bit 3 is the sense bit S and bits [2:0] are the line number. The byte takes effect from the clock edge on which aux_wr is sampled high.
- R2: U=0 enables the poll response. U=1 disables it, and then resp_lines stays 8'h00 whatever the bus and flag inputs are.
- R3: The line number in bits [2:0] is a binary index, and the response appears on resp_lines[index] (value 0 selects bit 0, value 7 selects bit 7).
- R4: The response bit is set only when the stored sense bit equals the service flag (S XNOR flag). A mismatch gives 8'h00.
- R5: resp_lines is nonzero only while bus_atn and bus_eoi are both high.
- R6: At most one bit of resp_lines is set at any time.
- R7: A cycle with srv_wr high loads srv_val into the service flag at that clock edge.
- R8: Synchronous active-high rst clears the service flag, the enable, the sense bit and the line number. The device then gives no response until it is configured again.
- R9: Writing the auxiliary byte 8'h02 is a local reset. It clears the same state as R8.
- R10: Any other auxiliary byte (bits [7:5] not 3'b011 and not 8'h02) leaves the configuration and the flag unchanged.
- R11: While enabled, resp_lines follows bus_atn and bus_eoi within the same cycle, with no clock edge needed.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_wr | input | 1 | Auxiliary mode byte write strobe |
| aux_data | input | 8 | Auxiliary mode byte |
| srv_wr | input | 1 | Service flag write strobe |
| srv_val | input | 1 | New service flag value |
| bus_atn | input | 1 | Bus ATN line, active high |
| bus_eoi | input | 1 | Bus EOI line, active high |
| resp_lines | output | 8 | Parallel poll response, one bit per data line |

## Verification
The hardest situation to reach from the ports is showing that a reset cleared the service flag and the sense bit. Nothing observable separates a cleared state from a disabled one. To reach it, the bench first sets the flag and the sense bit to 1 and enables the device. It then resets the device, through rst or through the 8'h02 byte. After that it writes only a new enable byte with sense 0 and does not write the flag. A response on the new line can appear only if the flag really returned to 0. The bench proves that unrelated auxiliary bytes are ignored in the same way: it keeps polling a configured line after writing them.

// File: rtl/pp_pkg.sv
package pp_pkg;
    parameter int PP_LINES = 8;
    localparam int PP_SEL_W = $clog2(PP_LINES);
    localparam int AUX_W = 8;
    localparam logic [2:0] CFG_TAG = 3'b011;
    localparam logic [AUX_W-1:0] CMD_LOCAL_RST = 8'h02;

    typedef struct packed {
        logic                en;
        logic                sense;
        logic [PP_SEL_W-1:0] sel;
    } pp_cfg_t;

    typedef enum logic [1:0] {
        AUX_IGNORE = 2'd0,
        AUX_CONFIG = 2'd1,
        AUX_RESET  = 2'd2
    } aux_kind_e;

    localparam pp_cfg_t CFG_CLEAR = '{en: 1'b0, sense: 1'b0, sel: '0};

    function automatic aux_kind_e classify_aux(input logic [AUX_W-1:0] b);
        if (b[7:5] == CFG_TAG)
            return AUX_CONFIG;
        else if (b == CMD_LOCAL_RST)
            return AUX_RESET;
        else
            return AUX_IGNORE;
    endfunction

    function automatic pp_cfg_t unpack_cfg(input logic [AUX_W-1:0] b);
        pp_cfg_t c;
        c.en    = ~b[4];
        c.sense = b[3];
        c.sel   = b[PP_SEL_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pp_aux_decode.sv
module pp_aux_decode
    import pp_pkg::*;
(
    input  logic             aux_wr,
    input  logic [AUX_W-1:0] aux_data,
    output logic             cfg_load,
    output logic             local_rst,
    output pp_cfg_t          cfg_next
);
    aux_kind_e kind;

    always_comb begin
        kind      = classify_aux(aux_data);
        cfg_load  = aux_wr && (kind == AUX_CONFIG);
        local_rst = aux_wr && (kind == AUX_RESET);
        cfg_next  = unpack_cfg(aux_data);
    end
endmodule

// File: rtl/pp_state.sv
module pp_state
    import pp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    local_rst,
    input  logic    cfg_load,
    input  pp_cfg_t cfg_next,
    input  logic    srv_wr,
    input  logic    srv_val,
    output pp_cfg_t cfg_q,
    output logic    ist_q
);
    always_ff @(posedge clk) begin
        if (rst || local_rst) begin
            cfg_q <= CFG_CLEAR;
            ist_q <= 1'b0;
        end else begin
            if (cfg_load)
                cfg_q <= cfg_next;
            if (srv_wr)
                ist_q <= srv_val;
        end
    end
endmodule

// File: rtl/pp_drive.sv
module pp_drive
    import pp_pkg::*;
(
    input  pp_cfg_t             cfg,
    input  logic                ist,
    input  logic                bus_atn,
    input  logic                bus_eoi,
    output logic [PP_LINES-1:0] resp
);
    logic answer;

    always_comb begin
        answer = cfg.en && bus_atn && bus_eoi && (cfg.sense ~^ ist);
    end

    for (genvar i = 0; i < PP_LINES; i++) begin : g_line
        assign resp[i] = answer && (cfg.sel == PP_SEL_W'(i));
    end
endmodule

// File: rtl/pp_responder.sv
module pp_responder
    import pp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                aux_wr,
    input  logic [AUX_W-1:0]    aux_data,
    input  logic                srv_wr,
    input  logic                srv_val,
    input  logic                bus_atn,
    input  logic                bus_eoi,
    output logic [PP_LINES-1:0] resp_lines
);
    logic    cfg_load;
    logic    local_rst;
    pp_cfg_t cfg_next;
    pp_cfg_t cfg_q;
    logic    ist_q;

    pp_aux_decode u_dec (
        .aux_wr    (aux_wr),
        .aux_data  (aux_data),
        .cfg_load  (cfg_load),
        .local_rst (local_rst),
        .cfg_next  (cfg_next)
    );

    pp_state u_state (
        .clk       (clk),
        .rst       (rst),
        .local_rst (local_rst),
        .cfg_load  (cfg_load),
        .cfg_next  (cfg_next),
        .srv_wr    (srv_wr),
        .srv_val   (srv_val),
        .cfg_q     (cfg_q),
        .ist_q     (ist_q)
    );

    pp_drive u_drive (
        .cfg     (cfg_q),
        .ist     (ist_q),
        .bus_atn (bus_atn),
        .bus_eoi (bus_eoi),
        .resp    (resp_lines)
    );
endmodule

// File: rtl/pp_responder_chk.sv
module pp_responder_chk
    import pp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                aux_wr,
    input logic [AUX_W-1:0]    aux_data,
    input logic                bus_atn,
    input logic                bus_eoi,
    input logic [PP_LINES-1:0] resp_lines
);
    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resp_lines));

    assert_idy_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_lines != '0) |-> (bus_atn && bus_eoi));

    assert_disable_R2: assert property (@(posedge clk) disable iff (rst)
        (aux_wr && aux_data[7:4] == 4'b0111) |=> (resp_lines == '0));

    assert_local_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (aux_wr && aux_data == CMD_LOCAL_RST) |=> (resp_lines == '0));

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (1'b0)
        (rst && !aux_wr) |=> (resp_lines == '0));
endmodule

bind pp_responder pp_responder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .aux_wr     (aux_wr),
    .aux_data   (aux_data),
    .bus_atn    (bus_atn),
    .bus_eoi    (bus_eoi),
    .resp_lines (resp_lines)
);

// File: tb/tb_pp_responder.sv
module tb_pp_responder;
    logic       clk = 1'b0;
    logic       rst;
    logic       aux_wr;
    logic [7:0] aux_data;
    logic       srv_wr;
    logic       srv_val;
    logic       bus_atn;
    logic       bus_eoi;
    logic [7:0] resp_lines;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    pp_responder dut (
        .clk        (clk),
        .rst        (rst),
        .aux_wr     (aux_wr),
        .aux_data   (aux_data),
        .srv_wr     (srv_wr),
        .srv_val    (srv_val),
        .bus_atn    (bus_atn),
        .bus_eoi    (bus_eoi),
        .resp_lines (resp_lines)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // {aux byte, flag, atn, eoi, expected response}
    localparam logic [18:0] VEC [0:9] = '{
        {8'h60, 1'b0, 1'b1, 1'b1, 8'h01},
        {8'h60, 1'b1, 1'b1, 1'b1, 8'h00},
        {8'h6B, 1'b1, 1'b1, 1'b1, 8'h08},
        {8'h6B, 1'b0, 1'b1, 1'b1, 8'h00},
        {8'h6F, 1'b1, 1'b1, 1'b1, 8'h80},
        {8'h6F, 1'b1, 1'b1, 1'b0, 8'h00},
        {8'h6F, 1'b1, 1'b0, 1'b1, 8'h00},
        {8'h7D, 1'b1, 1'b1, 1'b1, 8'h00},
        {8'h65, 1'b0, 1'b1, 1'b1, 8'h20},
        {8'h6A, 1'b1, 1'b1, 1'b1, 8'h04}
    };

    task automatic check(input logic [7:0] exp, input string req);
        checks = checks + 1;
        if (resp_lines !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%h expected=%h", req, resp_lines, exp);
        end
    endtask

    task automatic write_aux(input logic [7:0] b);
        @(negedge clk);
        aux_wr = 1'b1;
        aux_data = b;
        @(negedge clk);
        aux_wr = 1'b0;
    endtask

    task automatic write_flag(input logic v);
        @(negedge clk);
        srv_wr = 1'b1;
        srv_val = v;
        @(negedge clk);
        srv_wr = 1'b0;
    endtask

    task automatic poll(input logic a, input logic e);
        bus_atn = a;
        bus_eoi = e;
        #1;
    endtask

    initial begin
        rst = 1'b1; aux_wr = 1'b0; aux_data = '0; srv_wr = 1'b0; srv_val = 1'b0;
        bus_atn = 1'b0; bus_eoi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        poll(1'b1, 1'b1);
        check(8'h00, "R8 reset state");

        // Table walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 10; i++) begin
            poll(1'b0, 1'b0);
            write_aux(VEC[i][18:11]);
            write_flag(VEC[i][10]);
            poll(VEC[i][9], VEC[i][8]);
            check(VEC[i][7:0], "R1/R2/R3/R4/R5/R7 table vector");
        end

        // R11: combinational follow of bus lines while enabled
        write_aux(8'h6B);
        write_flag(1'b1);
        poll(1'b1, 1'b1);
        check(8'h08, "R11 atn+eoi asserted");
        poll(1'b1, 1'b0);
        check(8'h00, "R11 eoi dropped mid-cycle");
        poll(1'b1, 1'b1);
        check(8'h08, "R11 eoi restored mid-cycle");

        // R10: unrelated aux bytes ignored
        write_aux(8'h4F);
        check(8'h08, "R10 byte 4F ignored");
        write_aux(8'hEB);
        check(8'h08, "R10 byte EB ignored");
        write_aux(8'h00);
        check(8'h08, "R10 byte 00 ignored");

        // R8: rst clears flag, sense, enable
        write_aux(8'h6F);
        write_flag(1'b1);
        check(8'h80, "R8 setup before reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check(8'h00, "R8 no response after rst");
        write_aux(8'h61);
        check(8'h02, "R8 flag cleared by rst");

        // R9: local reset byte
        write_aux(8'h6F);
        write_flag(1'b1);
        check(8'h80, "R9 setup before local reset");
        write_aux(8'h02);
        check(8'h00, "R9 no response after local reset");
        write_aux(8'h66);
        check(8'h40, "R9 flag cleared by local reset");

        // R6: every line index yields one bit
        for (int n = 0; n < 8; n++) begin
            write_aux({5'b01100, 3'(n)});
            check(8'(1 << n), "R6/R3 single line per index");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule